// File: doc/BRIEF.md
# Keyed-Access Watchdog Timer

This block is a watchdog timer whose configuration is protected by magic key values. Software reaches it through three 32-bit registers: a control/status word, a counter word and a timeout limit word. The control word and the limit can only be changed while an unlock window is open. The window opens when the unlock key is written to the counter address. Writing the refresh key to the same address restarts the count. The key is one 32-bit word when the command-width bit is set, and two 16-bit halves written in order when it is clear.

When enabled, the counter advances on each pulse of an external tick input, or on every 256th pulse when the prescaler bit is set. When the count equals the limit, the block sets a timeout flag. With interrupts disabled it asserts its reset output at the same edge. With interrupts enabled it raises an interrupt first and asserts reset a fixed number of clocks later. The reset output stays high until the block itself is reset. Status bits in the control word show whether the window is open and whether the last configuration write has been applied.

Top module: `keyed_wdog`

## Requirements
- R1: After reset the control word reads 0x2420: command-width bit 13 = 1, update-allowed bit 5 = 1, applied bit 10 = 1, every other bit 0. The counter reads 0, the limit reads LIMIT_RST, and reset and interrupt outputs are 0.
- R2: With bit 13 set, writing 0xD928C520 to offset 0x4 opens the window. Bit 11 then reads 1 and the applied bit 10 reads 0.
- R3: With bit 13 clear, the window opens only when 0xC520 and then 0xD928 arrive in bits [15:0] of two consecutive writes to offset 0x4. Bits [31:16] are ignored in this mode.
- R4: The window closes WINDOW cycles after the last unlock. A write to the limit (0x8) or to the stored control fields (0x0) while the window is closed leaves them unchanged.
- R5: An accepted limit write updates the limit and sets bit 10, and the window stays open. An accepted control write updates the control fields, sets bit 10 and closes the window.
- R6: The refresh key clears the counter and the prescaler. It is 0xB480A602 in 32-bit mode, or 0xA602 followed by 0xB480 in 16-bit mode.
- R7: With enable bit 7 set, the counter gains one per tick pulse. With prescaler bit 12 also set, it gains one per 256 tick pulses.
- R8: After the first accepted control write, an unlock key is refused while update-allowed bit 5 is 0.
- R9: A counter-address write that is neither a key nor the awaited second half is ignored, and it cancels any pending first half.
- R10: With interrupt-enable bit 6 clear, when the count equals the limit, timeout flag bit 14 and the reset output rise at the same edge. The reset output stays high until block reset.
- R11: With bit 6 set, a timeout raises the interrupt at the flag edge, and the reset output rises DELAY cycles later. Writing 1 to bit 14 clears the flag and the interrupt, even when the block is locked.
- R12: Every accepted limit or control write restarts the count from 0, and the count never exceeds the limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Byte address of the read, result one cycle later |
| rd_data | output | 32 | Registered read data |
| tick_i | input | 1 | Counting tick from the selected clock source |
| wdog_rst_o | output | 1 | Sticky watchdog reset request |
| irq_o | output | 1 | Timeout interrupt |

## Verification
The assertions assume writes are single-cycle strobes to word-aligned offsets. They also assume the tick input is a synchronous enable in the block's clock domain. The stimulus drives every input at the falling edge, holds each write for exactly one rising edge, and uses only the three defined offsets. The random phases stay well inside one unlock window, so the key model in the bench never needs to track expiry. Window expiry is covered by a separate directed case.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
  localparam int DATA_W = 32;

  localparam logic [7:0] OFS_CTRL  = 8'h00;
  localparam logic [7:0] OFS_COUNT = 8'h04;
  localparam logic [7:0] OFS_LIMIT = 8'h08;

  // control word bit positions, decoded by software
  localparam int B_FLAG  = 14;
  localparam int B_CMD32 = 13;
  localparam int B_PRESC = 12;
  localparam int B_ULK   = 11;
  localparam int B_DONE  = 10;
  localparam int B_CLKHI = 9;
  localparam int B_CLKLO = 8;
  localparam int B_EN    = 7;
  localparam int B_IEN   = 6;
  localparam int B_UPD   = 5;
  localparam int B_WAIT  = 1;
  localparam int B_STOP  = 0;

  localparam logic [31:0] KEY_OPEN32 = 32'hD928_C520;
  localparam logic [31:0] KEY_FEED32 = 32'hB480_A602;
  localparam logic [15:0] OPEN_LO    = 16'hC520;
  localparam logic [15:0] OPEN_HI    = 16'hD928;
  localparam logic [15:0] FEED_LO    = 16'hA602;
  localparam logic [15:0] FEED_HI    = 16'hB480;

  typedef enum logic [1:0] {
    KS_IDLE = 2'd0,
    KS_OPEN = 2'd1,
    KS_FEED = 2'd2
  } key_st_t;
endpackage

// File: rtl/wdk_keys.sv
module wdk_keys
  import wdk_pkg::*;
#(
  parameter int WINDOW = 255
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              key_wr,
  input  logic [DATA_W-1:0] key_data,
  input  logic              mode32,
  input  logic              allow,
  input  logic              close,
  output logic              unlock_o,
  output logic              refresh_o,
  output logic              ulk_o
);
  localparam int WIN_W = $clog2(WINDOW + 1);

  key_st_t           st_q, st_d;
  logic [WIN_W-1:0]  win_q;
  logic              open_hit, feed_hit;
  logic [15:0]       lo;

  assign lo = key_data[15:0];

  always_comb begin
    st_d     = st_q;
    open_hit = 1'b0;
    feed_hit = 1'b0;
    if (key_wr) begin
      st_d = KS_IDLE;
      if (mode32) begin
        open_hit = (key_data == KEY_OPEN32);
        feed_hit = (key_data == KEY_FEED32);
      end else if (st_q == KS_OPEN && lo == OPEN_HI) begin
        open_hit = 1'b1;
      end else if (st_q == KS_FEED && lo == FEED_HI) begin
        feed_hit = 1'b1;
      end else if (lo == OPEN_LO) begin
        st_d = KS_OPEN;
      end else if (lo == FEED_LO) begin
        st_d = KS_FEED;
      end
    end
  end

  assign unlock_o  = open_hit & allow;
  assign refresh_o = feed_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= KS_IDLE;
      ulk_o <= 1'b0;
      win_q <= '0;
    end else begin
      st_q <= st_d;
      if (unlock_o) begin
        ulk_o <= 1'b1;
        win_q <= WIN_W'(WINDOW - 1);
      end else if (close) begin
        ulk_o <= 1'b0;
      end else if (ulk_o) begin
        if (win_q == '0) ulk_o <= 1'b0;
        else             win_q <= win_q - 1'b1;
      end
    end
  end

  // R2: the window only opens after a write to the key address
  p_open_needs_key_r2: assert property (@(posedge clk) disable iff (rst)
    (ulk_o && !$past(ulk_o)) |-> $past(key_wr));

  // R4: an open window with no time left and no new key closes
  p_window_ends_r4: assert property (@(posedge clk) disable iff (rst)
    (ulk_o && win_q == '0 && !key_wr) |=> !ulk_o);
endmodule

// File: rtl/wdk_counter.sv
module wdk_counter #(
  parameter int CNT_W   = 32,
  parameter int PRE_DIV = 256,
  parameter int DELAY   = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             en,
  input  logic             presc,
  input  logic             ien,
  input  logic [CNT_W-1:0] limit,
  input  logic             restart,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] count_o,
  output logic             flag_o,
  output logic             irq_o,
  output logic             wrst_o
);
  localparam int PRE_W = $clog2(PRE_DIV);
  localparam int DLY_W = $clog2(DELAY + 1);

  logic [PRE_W-1:0] pre_q;
  logic [DLY_W-1:0] dly_q;
  logic             pend_q;
  logic             run, step, hit, pre_wrap;

  assign run      = en & ~flag_o;
  assign pre_wrap = (pre_q == PRE_W'(PRE_DIV - 1));
  assign step     = tick & (~presc | pre_wrap);
  assign hit      = run & (count_o == limit);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      count_o <= '0;
      pre_q   <= '0;
    end else if (run && tick) begin
      if (presc) pre_q <= pre_wrap ? '0 : pre_q + 1'b1;
      if (step && count_o != limit) count_o <= count_o + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_o <= 1'b0;
      irq_o  <= 1'b0;
      pend_q <= 1'b0;
      dly_q  <= '0;
      wrst_o <= 1'b0;
    end else begin
      if (hit) begin
        flag_o <= 1'b1;
        if (ien) irq_o <= 1'b1;
      end else if (flag_clr) begin
        flag_o <= 1'b0;
        irq_o  <= 1'b0;
      end
      if (hit && ien && !pend_q) begin
        pend_q <= 1'b1;
        dly_q  <= '0;
      end else if (pend_q && !wrst_o) begin
        if (dly_q == DLY_W'(DELAY - 1)) wrst_o <= 1'b1;
        else                            dly_q  <= dly_q + 1'b1;
      end
      if (hit && !ien) wrst_o <= 1'b1;
    end
  end

  // R10: the reset request never drops before block reset
  p_rst_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    wrst_o |=> wrst_o);

  // R11: the interrupt is only ever shown alongside the flag
  p_irq_with_flag_r11: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> flag_o);

  // R12: the count stays at or below the limit
  p_count_le_limit_r12: assert property (@(posedge clk) disable iff (rst)
    count_o <= limit);
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
  import wdk_pkg::*;
#(
  parameter int          ADDR_W    = 4,
  parameter int          CNT_W     = 32,
  parameter int          WINDOW    = 255,
  parameter int          PRE_DIV   = 256,
  parameter int          DELAY     = 16,
  parameter logic [31:0] LIMIT_RST = 32'd1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  input  logic              tick_i,
  output logic              wdog_rst_o,
  output logic              irq_o
);
  logic             cmd32_q, presc_q, en_q, ien_q, upd_q, wait_q, stop_q;
  logic [1:0]       csel_q;
  logic             done_q, cfg_seen_q;
  logic [CNT_W-1:0] limit_q, count;
  logic             ulk, unlock, refresh, flag;
  logic             wr_ctrl, wr_cnt, wr_lim, acc_ctrl, acc_lim;

  assign wr_ctrl  = wr_en && (wr_addr == ADDR_W'(OFS_CTRL));
  assign wr_cnt   = wr_en && (wr_addr == ADDR_W'(OFS_COUNT));
  assign wr_lim   = wr_en && (wr_addr == ADDR_W'(OFS_LIMIT));
  assign acc_ctrl = wr_ctrl & ulk;
  assign acc_lim  = wr_lim & ulk;

  wdk_keys #(.WINDOW(WINDOW)) u_keys (
    .clk      (clk),
    .rst      (rst),
    .key_wr   (wr_cnt),
    .key_data (wr_data),
    .mode32   (cmd32_q),
    .allow    (~cfg_seen_q | upd_q),
    .close    (acc_ctrl),
    .unlock_o (unlock),
    .refresh_o(refresh),
    .ulk_o    (ulk)
  );

  wdk_counter #(.CNT_W(CNT_W), .PRE_DIV(PRE_DIV), .DELAY(DELAY)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick_i),
    .en      (en_q),
    .presc   (presc_q),
    .ien     (ien_q),
    .limit   (limit_q),
    .restart (refresh | acc_ctrl | acc_lim),
    .flag_clr(wr_ctrl & wr_data[B_FLAG]),
    .count_o (count),
    .flag_o  (flag),
    .irq_o   (irq_o),
    .wrst_o  (wdog_rst_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd32_q    <= 1'b1;
      presc_q    <= 1'b0;
      csel_q     <= 2'b00;
      en_q       <= 1'b0;
      ien_q      <= 1'b0;
      upd_q      <= 1'b1;
      wait_q     <= 1'b0;
      stop_q     <= 1'b0;
      done_q     <= 1'b1;
      cfg_seen_q <= 1'b0;
      limit_q    <= LIMIT_RST[CNT_W-1:0];
    end else begin
      if (acc_ctrl) begin
        cmd32_q    <= wr_data[B_CMD32];
        presc_q    <= wr_data[B_PRESC];
        csel_q     <= wr_data[B_CLKHI:B_CLKLO];
        en_q       <= wr_data[B_EN];
        ien_q      <= wr_data[B_IEN];
        upd_q      <= wr_data[B_UPD];
        wait_q     <= wr_data[B_WAIT];
        stop_q     <= wr_data[B_STOP];
        cfg_seen_q <= 1'b1;
      end
      if (acc_lim) limit_q <= wr_data[CNT_W-1:0];
      if (unlock)                   done_q <= 1'b0;
      else if (acc_ctrl || acc_lim) done_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      rd_data <= '0;
      if (rd_addr == ADDR_W'(OFS_CTRL)) begin
        rd_data[B_FLAG]          <= flag;
        rd_data[B_CMD32]         <= cmd32_q;
        rd_data[B_PRESC]         <= presc_q;
        rd_data[B_ULK]           <= ulk;
        rd_data[B_DONE]          <= done_q;
        rd_data[B_CLKHI:B_CLKLO] <= csel_q;
        rd_data[B_EN]            <= en_q;
        rd_data[B_IEN]           <= ien_q;
        rd_data[B_UPD]           <= upd_q;
        rd_data[B_WAIT]          <= wait_q;
        rd_data[B_STOP]          <= stop_q;
      end else if (rd_addr == ADDR_W'(OFS_COUNT)) begin
        rd_data[CNT_W-1:0] <= count;
      end else if (rd_addr == ADDR_W'(OFS_LIMIT)) begin
        rd_data[CNT_W-1:0] <= limit_q;
      end
    end
  end

  // R4: the limit only changes if the window was open
  p_limit_locked_r4: assert property (@(posedge clk) disable iff (rst)
    (limit_q != $past(limit_q)) |-> $past(ulk));

  // R5: an accepted control write leaves the window closed
  p_ctrl_closes_r5: assert property (@(posedge clk) disable iff (rst)
    acc_ctrl |=> !ulk);
endmodule

// File: tb/keyed_wdog_bench.sv
module keyed_wdog_bench;
  localparam int WIN = 100;
  localparam int DLY = 8;
  localparam logic [31:0] LRST = 32'd1000;
  localparam logic [3:0] A_CTRL = 4'h0, A_CNT = 4'h4, A_LIM = 4'h8;
  localparam logic [31:0] OPEN32 = 32'hD928_C520, FEED32 = 32'hB480_A602;

  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0, tick_i = 1'b0;
  logic [3:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic wdog_rst_o, irq_o;
  int n_chk = 0, n_err = 0;
  logic [31:0] v;

  always #5 clk = ~clk;

  keyed_wdog #(.WINDOW(WIN), .DELAY(DLY), .LIMIT_RST(LRST)) u_keyed_wdog (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .tick_i(tick_i),
    .wdog_rst_o(wdog_rst_o), .irq_o(irq_o));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); rd_addr = a;
    @(negedge clk); d = rd_data;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; tick_i = 1'b0;
    repeat (2) @(negedge clk); rst = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tick_i = 1'b1;
    repeat (n) @(negedge clk);
    tick_i = 1'b0;
  endtask

  // key decoder model: st 0 idle, 1 open half seen, 2 feed half seen
  function automatic void model_key(input bit m32, input logic [31:0] d,
                                    inout int st, inout bit ulk);
    logic [15:0] lo = d[15:0];
    if (m32) begin
      st = 0;
      if (d == OPEN32) ulk = 1'b1;
    end else if (st == 1 && lo == 16'hD928) begin
      st = 0; ulk = 1'b1;
    end else if (st == 2 && lo == 16'hB480) begin
      st = 0;
    end else if (lo == 16'hC520) st = 1;
    else if (lo == 16'hA602) st = 2;
    else st = 0;
  endfunction

  function automatic logic [31:0] pick_data(input int c);
    logic [15:0] up = 16'($urandom);
    case (c)
      0: return OPEN32;
      1: return FEED32;
      2: return {up, 16'hC520};
      3: return {up, 16'hD928};
      4: return {up, 16'hA602};
      5: return {up, 16'hB480};
      default: return ($urandom & 32'h0FFF_0FFF) | 32'h0000_1000;
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk); rst = 1'b0;

    // R1 reset state
    rd(A_CTRL, v); check("R1 ctrl", v, 32'h2420);
    rd(A_CNT, v);  check("R1 count", v, 0);
    rd(A_LIM, v);  check("R1 limit", v, LRST);
    check("R1 outputs", {30'd0, wdog_rst_o, irq_o}, 0);

    // R4 locked limit write ignored
    wr(A_LIM, 32'd77); rd(A_LIM, v); check("R4 locked limit", v, LRST);

    // R2 / R5 unlock and configuration
    wr(A_CNT, OPEN32); rd(A_CTRL, v); check("R2 open32", v, 32'h2820);
    wr(A_LIM, 32'h55); rd(A_LIM, v); check("R5 limit", v, 32'h55);
    rd(A_CTRL, v); check("R5 limit keeps window", v, 32'h2C20);
    wr(A_CTRL, 32'h2022); rd(A_CTRL, v); check("R5 ctrl closes", v, 32'h2422);

    // R4 window expiry
    wr(A_CNT, OPEN32);
    repeat (WIN - 10) @(negedge clk);
    rd(A_CTRL, v); check("R4 still open", v[11], 1'b1);
    repeat (12) @(negedge clk);
    rd(A_CTRL, v); check("R4 expired", v[11], 1'b0);
    wr(A_LIM, 32'd7); rd(A_LIM, v); check("R4 late limit", v, 32'h55);

    // R3 / R9 16-bit keys
    do_reset();
    wr(A_CNT, OPEN32); wr(A_CTRL, 32'h0020);
    wr(A_CNT, 32'hFFFF_C520); wr(A_CNT, 32'h1234_D928);
    rd(A_CTRL, v); check("R3 halves open", v, 32'h0820);
    wr(A_CTRL, 32'h0020);
    wr(A_CNT, 32'h0000_C520); wr(A_CNT, 32'h0000_1234); wr(A_CNT, 32'h0000_D928);
    rd(A_CTRL, v); check("R9 broken sequence", v[11], 1'b0);

    // R8 refusal after update-allowed cleared
    do_reset();
    wr(A_CNT, OPEN32); wr(A_CTRL, 32'h2000);
    wr(A_CNT, OPEN32); rd(A_CTRL, v); check("R8 refused", v[11], 1'b0);
    wr(A_LIM, 32'd5); rd(A_LIM, v); check("R8 limit kept", v, LRST);

    // R7 / R6 / R12 counting, prescaler, refresh
    do_reset();
    wr(A_CNT, OPEN32); wr(A_CTRL, 32'h20A0);
    ticks(37); rd(A_CNT, v); check("R7 plain count", v, 37);
    wr(A_CNT, FEED32); rd(A_CNT, v); check("R6 refresh32", v, 0);
    wr(A_CNT, OPEN32); wr(A_CTRL, 32'h10A0);
    ticks(512); rd(A_CNT, v); check("R7 prescaled", v, 2);
    wr(A_CNT, 32'h0000_A602); wr(A_CNT, 32'h0000_B480);
    rd(A_CNT, v); check("R6 refresh halves", v, 0);
    ticks(256); rd(A_CNT, v); check("R7 one prescaled step", v, 1);
    wr(A_CNT, 32'h0000_C520); wr(A_CNT, 32'h0000_D928); wr(A_LIM, 32'd5000);
    rd(A_CNT, v); check("R12 restart on limit write", v, 0);

    // R10 timeout without interrupt
    do_reset();
    wr(A_CNT, OPEN32); wr(A_LIM, 32'd20); wr(A_CTRL, 32'h20A0);
    @(negedge clk); tick_i = 1'b1;
    for (int i = 0; i < 5; i++) begin
      repeat (8) @(negedge clk);
      wr(A_CNT, FEED32);
    end
    check("R10 fed no reset", {31'd0, wdog_rst_o}, 0);
    repeat (20) @(negedge clk);
    check("R10 not yet", {31'd0, wdog_rst_o}, 0);
    @(negedge clk);
    check("R10 reset at limit", {30'd0, wdog_rst_o, irq_o}, 32'd2);
    tick_i = 1'b0;
    rd(A_CTRL, v); check("R10 flag", v[14], 1'b1);

    // R11 timeout with interrupt
    do_reset();
    wr(A_CNT, OPEN32); wr(A_LIM, 32'd10); wr(A_CTRL, 32'h20E0);
    tick_i = 1'b1;
    repeat (10) @(negedge clk);
    check("R11 irq not yet", {31'd0, irq_o}, 0);
    @(negedge clk);
    check("R11 irq at flag", {30'd0, wdog_rst_o, irq_o}, 32'd1);
    repeat (DLY - 1) @(negedge clk);
    check("R11 reset delayed", {31'd0, wdog_rst_o}, 0);
    @(negedge clk);
    check("R11 reset after delay", {31'd0, wdog_rst_o}, 1);
    tick_i = 1'b0;
    wr(A_CNT, OPEN32); wr(A_CTRL, 32'h6020);
    rd(A_CTRL, v); check("R11 flag cleared", v[14], 1'b0);
    check("R11 irq cleared, R10 reset sticky", {30'd0, wdog_rst_o, irq_o}, 32'd2);

    // random key sequences against the model (R2 R3 R9)
    for (int ph = 0; ph < 10; ph++) begin
      bit m32 = ph[0];
      int st = 0;
      bit ulk = 1'b0;
      do_reset();
      if (!m32) begin wr(A_CNT, OPEN32); wr(A_CTRL, 32'h0020); end
      for (int k = 0; k < 12; k++) begin
        logic [31:0] d = pick_data($urandom_range(0, 6));
        wr(A_CNT, d);
        model_key(m32, d, st, ulk);
        rd(A_CTRL, v);
        check(m32 ? "R2 random open32" : "R3 R9 random halves", {31'd0, v[11]}, {31'd0, ulk});
      end
    end

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule